// File: doc/BRIEF.md
# Parallel-Lane Stride Reorder Buffer

This block reorders a frame of `FRAME` samples that arrives `LANES` samples per beat. Frames come in one index ordering and leave in the other. In continuous order, beat k carries indices k*LANES through k*LANES+LANES-1. In strided order, lane j of beat k carries index k + j*S, where S = FRAME/LANES is also the number of beats per frame. The parameter `IN_ORDER` fixes the input ordering, and the output always uses the opposite one. The block sits between a wide multi-sample datapath and a transform stage whose bins or samples must be grouped by stride. It only reorders and leaves the sample values untouched.

Storage is split into `LANES` banks. Each bank holds two frames, so one frame is written while the previous one is read. A sample's bank is its low index field plus its high index field, modulo `LANES`. As a result, every beat in either ordering touches each bank exactly once, and a full beat is written and read in one cycle. Both sides use valid/ready. Each output lane carries the frame index of its sample next to the data.

Top module: `stride_reorder`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: With `IN_ORDER = ORDER_CONT` (input lane l of beat k holds index k*LANES+l), output beat k lane j carries the sample written at index k + j*S, where S = FRAME/LANES.
- R3: With `IN_ORDER = ORDER_STRIDE` (input lane l of beat k holds index k + l*S), output beat k lane j carries the sample written at index k*LANES + j.
- R4: Lane j of `out_index_o`, bits [j*IDX_W +: IDX_W], equals the frame index of the sample on lane j of `out_data_o`. Its low log2(LANES) bits equal j in continuous output order, and its high log2(LANES) bits equal j in strided output order.
- R5: Frames leave in the order they arrived, and within a frame the beats leave in ascending beat order.
- R6: With `out_ready_i` held high, back-to-back input frames are accepted at one beat per cycle and `in_ready_o` never drops.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, on the next cycle `out_valid_o` stays 1 and `out_data_o` and `out_index_o` do not change.
- R8: Once two frames are stored and not yet fully read, `in_ready_o` is 0. Input beats offered while `in_ready_o` is 0 are discarded and do not reach the output.
- R9: In every written beat and every read beat, each bank is addressed by exactly one lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take an input beat |
| in_data_i | input | LANES*DATA_W | Input lanes, lane l at [l*DATA_W +: DATA_W] |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream takes the output beat |
| out_data_o | output | LANES*DATA_W | Reordered output lanes |
| out_index_o | output | LANES*IDX_W | Frame index of each output lane, IDX_W = log2(FRAME) |

## Verification
The bench writes each sample as its index plus a frame tag. Because of this, a wrong bank rotation or bank address shows up at the ports on the first affected output beat as a value on the wrong lane or a value from the wrong index. This happens within one frame of latency. A wrong ping-pong flag appears in the same frame as a duplicated frame, a skipped frame, a stale frame tag, or an `in_ready_o` that stays high past two stored frames. A stall-path fault changes held data on the cycle right after `out_ready_i` drops.

// File: rtl/stride_reorder_pkg.sv
package stride_reorder_pkg;
  typedef enum logic {
    ORDER_CONT   = 1'b0,
    ORDER_STRIDE = 1'b1
  } order_e;
endpackage

// File: rtl/stride_index_gen.sv
module stride_index_gen
  import stride_reorder_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned FRAME = 32,
  parameter order_e      ORDER = ORDER_CONT,
  localparam int unsigned IDX_W  = $clog2(FRAME),
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned BEAT_W = $clog2(FRAME / LANES)
) (
  input  logic [BEAT_W-1:0]             beat_i,
  output logic [LANES-1:0][IDX_W-1:0]   idx_o,
  output logic [LANES-1:0][LANE_W-1:0]  bank_o,
  output logic [LANES-1:0][BEAT_W-1:0]  addr_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LANE_W-1:0] LN = LANE_W'(l);
    if (ORDER == ORDER_CONT) begin : g_cont
      assign idx_o[l] = {beat_i, LN};
    end else begin : g_strd
      assign idx_o[l] = {LN, beat_i};
    end
    // bank skew: low field rotated by high field
    assign bank_o[l] = idx_o[l][LANE_W-1:0] + idx_o[l][IDX_W-1 -: LANE_W];
    assign addr_o[l] = idx_o[l][IDX_W-1:LANE_W];
  end
endmodule

// File: rtl/stride_bank_route.sv
module stride_bank_route #(
  parameter int unsigned LANES = 4,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          chk_i,
  input  logic [LANES-1:0][LANE_W-1:0]  bank_i,
  output logic [LANES-1:0][LANE_W-1:0]  lane_o
);
  always_comb begin
    lane_o = '0;
    for (int l = 0; l < LANES; l++) lane_o[bank_i[l]] = LANE_W'(l);
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LANES-1:0] hit;
    for (genvar l = 0; l < LANES; l++) begin : g_hit
      assign hit[l] = (bank_i[l] == LANE_W'(b));
    end
    // R9
    bank_single_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_i |-> $countones(hit) == 1);
  end
endmodule

// File: rtl/stride_bank_mem.sv
module stride_bank_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [2**ADDR_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/stride_reorder.sv
module stride_reorder
  import stride_reorder_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANES    = 4,
  parameter int unsigned FRAME    = 32,
  parameter order_e      IN_ORDER = ORDER_CONT,
  localparam int unsigned IDX_W   = $clog2(FRAME)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [LANES*DATA_W-1:0] in_data_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [LANES*DATA_W-1:0] out_data_o,
  output logic [LANES*IDX_W-1:0]  out_index_o
);
  localparam int unsigned BEATS  = FRAME / LANES;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned BEAT_W = $clog2(BEATS);
  localparam int unsigned MEM_AW = BEAT_W + 1;
  localparam order_e OUT_ORDER = (IN_ORDER == ORDER_CONT) ? ORDER_STRIDE : ORDER_CONT;

  logic              wr_buf_q, rd_buf_q;
  logic [BEAT_W-1:0] wr_beat_q, rd_beat_q;
  logic [1:0]        full_q;
  logic              out_valid_q;
  logic [LANES-1:0][LANE_W-1:0] rbank_q;
  logic [LANES-1:0][IDX_W-1:0]  out_index_q;

  logic wr_fire, wr_last, rd_issue, rd_last;
  logic [LANES-1:0][DATA_W-1:0] in_lanes;
  logic [LANES-1:0][IDX_W-1:0]  w_idx, r_idx;
  logic [LANES-1:0][LANE_W-1:0] w_bank, r_bank, w_lane, r_lane;
  logic [LANES-1:0][BEAT_W-1:0] w_addr, r_addr;
  logic [DATA_W-1:0]            bank_rdata [LANES];

  assign in_lanes   = in_data_i;
  assign in_ready_o = !full_q[wr_buf_q];
  assign wr_fire    = in_valid_i && in_ready_o;
  assign wr_last    = (wr_beat_q == BEAT_W'(BEATS - 1));
  assign rd_issue   = full_q[rd_buf_q] && (!out_valid_q || out_ready_i);
  assign rd_last    = (rd_beat_q == BEAT_W'(BEATS - 1));

  stride_index_gen #(.LANES(LANES), .FRAME(FRAME), .ORDER(IN_ORDER)) u_wgen (
    .beat_i(wr_beat_q), .idx_o(w_idx), .bank_o(w_bank), .addr_o(w_addr));
  stride_index_gen #(.LANES(LANES), .FRAME(FRAME), .ORDER(OUT_ORDER)) u_rgen (
    .beat_i(rd_beat_q), .idx_o(r_idx), .bank_o(r_bank), .addr_o(r_addr));

  stride_bank_route #(.LANES(LANES)) u_wroute (
    .clk_i, .rst_ni, .chk_i(wr_fire), .bank_i(w_bank), .lane_o(w_lane));
  stride_bank_route #(.LANES(LANES)) u_rroute (
    .clk_i, .rst_ni, .chk_i(rd_issue), .bank_i(r_bank), .lane_o(r_lane));

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    stride_bank_mem #(.DATA_W(DATA_W), .ADDR_W(MEM_AW)) u_mem (
      .clk_i,
      .we_i   (wr_fire),
      .waddr_i({wr_buf_q, w_addr[w_lane[b]]}),
      .wdata_i(in_lanes[w_lane[b]]),
      .re_i   (rd_issue),
      .raddr_i({rd_buf_q, r_addr[r_lane[b]]}),
      .rdata_o(bank_rdata[b])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign out_data_o[l*DATA_W +: DATA_W] = bank_rdata[rbank_q[l]];
  end
  assign out_index_o = out_index_q;
  assign out_valid_o = out_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_buf_q    <= 1'b0;
      wr_beat_q   <= '0;
      rd_buf_q    <= 1'b0;
      rd_beat_q   <= '0;
      full_q      <= '0;
      out_valid_q <= 1'b0;
      rbank_q     <= '0;
      out_index_q <= '0;
    end else begin
      if (wr_fire) begin
        wr_beat_q <= wr_beat_q + 1'b1;
        if (wr_last) begin
          full_q[wr_buf_q] <= 1'b1;
          wr_buf_q         <= !wr_buf_q;
        end
      end
      if (rd_issue) begin
        rd_beat_q   <= rd_beat_q + 1'b1;
        rbank_q     <= r_bank;
        out_index_q <= r_idx;
        if (rd_last) begin
          full_q[rd_buf_q] <= 1'b0;
          rd_buf_q         <= !rd_buf_q;
        end
      end
      if (rd_issue)         out_valid_q <= 1'b1;
      else if (out_ready_i) out_valid_q <= 1'b0;
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_index_o));

  // R8
  both_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && wr_last && full_q[!wr_buf_q] && !(rd_issue && rd_last) |=> !in_ready_o);

  for (genvar l = 0; l < LANES; l++) begin : g_idx_chk
    if (OUT_ORDER == ORDER_CONT) begin : g_c
      // R4
      lane_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> out_index_o[l*IDX_W +: LANE_W] == LANE_W'(l));
    end else begin : g_s
      // R4
      lane_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> out_index_o[l*IDX_W + IDX_W - LANE_W +: LANE_W] == LANE_W'(l));
    end
  end
endmodule

// File: tb/stride_reorder_tb_top.sv
module stride_reorder_tb_top;
  import stride_reorder_pkg::*;
  localparam int DW = 16;
  localparam int P  = 4;
  localparam int N  = 32;
  localparam int M  = N / P;
  localparam int IW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [P*DW-1:0] din_a = '0, din_b = '0;
  logic rdy_a, rdy_b, ov_a, ov_b;
  logic [P*DW-1:0] od_a, od_b;
  logic [P*IW-1:0] oi_a, oi_b;

  stride_reorder #(.DATA_W(DW), .LANES(P), .FRAME(N), .IN_ORDER(ORDER_CONT)) dut_i (
    .clk_i, .rst_ni, .in_valid_i(in_valid), .in_ready_o(rdy_a), .in_data_i(din_a),
    .out_valid_o(ov_a), .out_ready_i(out_ready), .out_data_o(od_a), .out_index_o(oi_a));
  stride_reorder #(.DATA_W(DW), .LANES(P), .FRAME(N), .IN_ORDER(ORDER_STRIDE)) dut_rev_i (
    .clk_i, .rst_ni, .in_valid_i(in_valid), .in_ready_o(rdy_b), .in_data_i(din_b),
    .out_valid_o(ov_b), .out_ready_i(out_ready), .out_data_o(od_b), .out_index_o(oi_b));

  int checks = 0, errors = 0;
  int in_fr = 0, in_bt = 0, target = 0, stalls = 0, accepted = 0;
  int fr [2] = '{0, 0};
  int bt [2] = '{0, 0};
  bit held [2] = '{0, 0};
  logic [P*DW-1:0] held_d [2];
  logic [P*IW-1:0] held_i [2];
  bit wd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon(input int w, input logic v, input logic [P*DW-1:0] d,
                     input logic [P*IW-1:0] ix);
    if (held[w]) begin
      chk(v == 1'b1, "R7", "valid held under stall", v, 1);
      chk(d == held_d[w], "R7", "data held under stall", d, held_d[w]);
      chk(ix == held_i[w], "R7", "index held under stall", ix, held_i[w]);
    end
    if (v && out_ready) begin
      for (int j = 0; j < P; j++) begin
        int e_idx;
        int e_dat;
        e_idx = (w == 0) ? bt[w] + j * M : bt[w] * P + j;
        e_dat = fr[w] * 64 + e_idx;
        chk(ix[j*IW +: IW] == IW'(e_idx), "R4", "lane index", ix[j*IW +: IW], e_idx);
        chk(d[j*DW +: DW] == DW'(e_dat), (w == 0) ? "R2/R5/R9" : "R3/R5/R9",
            "lane data", d[j*DW +: DW], e_dat);
      end
      bt[w]++;
      if (bt[w] == M) begin
        bt[w] = 0;
        fr[w]++;
      end
    end
    held[w]   = v && !out_ready;
    held_d[w] = d;
    held_i[w] = ix;
  endtask

  task automatic step(input bit want, input bit rdy, input bit garbage, input bit count_stall);
    @(negedge clk_i);
    out_ready = rdy;
    if (garbage) begin
      in_valid = !rdy_a;
      din_a = '1;
      din_b = '1;
    end else begin
      in_valid = want && (in_fr < target);
      for (int l = 0; l < P; l++) begin
        din_a[l*DW +: DW] = DW'(in_fr * 64 + in_bt * P + l);
        din_b[l*DW +: DW] = DW'(in_fr * 64 + l * M + in_bt);
      end
    end
    #1;
    if (rdy_a != rdy_b) chk(0, "R6", "ready mismatch between directions", rdy_b, rdy_a);
    if (count_stall && in_valid && !rdy_a) stalls++;
    mon(0, ov_a, od_a, oi_a);
    mon(1, ov_b, od_b, oi_b);
    if (in_valid && rdy_a && !garbage) begin
      accepted++;
      in_bt++;
      if (in_bt == M) begin
        in_bt = 0;
        in_fr++;
      end
    end
  endtask

  task automatic drain();
    while ((fr[0] < target || fr[1] < target) && !wd) step(0, 1, 0, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk_i);
    wd = 1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(ov_a == 1'b0, "R1", "out_valid after reset", ov_a, 0);
    chk(ov_b == 1'b0, "R1", "out_valid after reset (rev)", ov_b, 0);
    chk(rdy_a == 1'b1, "R1", "in_ready after reset", rdy_a, 1);
    chk(rdy_b == 1'b1, "R1", "in_ready after reset (rev)", rdy_b, 1);

    // back-to-back frames, no backpressure
    target = 3;
    while (in_fr < target && !wd) step(1, 1, 0, 1);
    chk(stalls == 0, "R6", "input stall cycles in full-rate stream", stalls, 0);
    drain();

    // random gaps and backpressure
    target = 7;
    while (in_fr < target && !wd) step(($urandom % 4) != 0, ($urandom % 3) != 0, 0, 0);
    drain();

    // fill both buffers, then offer discarded beats
    target = 9;
    accepted = 0;
    do step(1, 0, 0, 0); while (rdy_a && !wd);
    chk(accepted == 2 * M, "R8", "beats accepted before ready drops", accepted, 2 * M);
    chk(rdy_a == 1'b0, "R8", "in_ready low with two stored frames", rdy_a, 0);
    repeat (6) step(0, 0, 1, 0);
    chk(accepted == 2 * M, "R8", "beats accepted while not ready", accepted, 2 * M);
    drain();

    repeat (4) step(0, 1, 0, 0);
    chk(ov_a == 1'b0 && ov_b == 1'b0, "R8", "no extra output after discarded beats",
        ov_a | ov_b, 0);
    chk(rdy_a == 1'b1, "R6", "in_ready after drain", rdy_a, 1);
    chk(fr[0] == 9 && fr[1] == 9, "R5", "frames delivered", fr[0] + fr[1], 18);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule